// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Register

This block collects three event sources, which are a periodic tick, an alarm match and an update-ended notice, into sticky flags. A host reads them back as one status byte. Each flag latches when its event pulse arrives, whether or not its enable is set. A summary bit is formed from the flags that are enabled. The summary bit drives an active-high enable for an external open-drain, active-low interrupt pull-down.

The read strobe is a level that stays high for the whole host read. While the strobe is high, the flags are frozen, so the byte the host sees cannot change during the read. Events that arrive during the read are parked in pending latches. On the trailing edge of the strobe, every flag is cleared, and in the same step the parked events and any event in that cycle are loaded into the flags. No event is lost.

Entering set mode masks the update-ended enable. It also issues a one-cycle request that tells the enable storage to clear that bit.

Top module: `irq_status_reg`

## Requirements
- R1: After reset, `status_o` is 8'h00 and `irq_drive_o` is 0. Bits 3..0 of `status_o` always read 0.
- R2: `status_o[7]` equals the OR of three terms: periodic flag AND `en_i[2]`, alarm flag AND `en_i[1]`, and update flag AND `en_i[0]` AND NOT `set_mode_i`. It is combinational from the enables.
- R3: An event pulse on `evt_i[2]` (periodic), `evt_i[1]` (alarm) or `evt_i[0]` (update) in a cycle outside a read sets `status_o[6]`, `[5]` or `[4]` respectively after that clock edge. The enable state has no effect on this.
- R4: `irq_drive_o` is 1 exactly when `status_o[7]` is 1.
- R5: On the first clock edge at which `rd_i` is low after being high, all flags are cleared.
- R6: While `rd_i` is high, `status_o[6:4]` does not change. Events seen during the read set their flags at the trailing-edge clock instead. An event in that same trailing-edge cycle also sets its flag.
- R7: A flag that is already set raises the summary and `irq_drive_o` in the same cycle that its enable goes to 1.
- R8: `upd_en_clr_o` is 1 exactly in the first cycle in which `set_mode_i` is sampled high after being low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 3 | Event pulses: [2] periodic, [1] alarm, [0] update-ended |
| en_i | input | 3 | Interrupt enables, same bit order as evt_i |
| set_mode_i | input | 1 | Set mode active |
| rd_i | input | 1 | Status read strobe, high for the whole read |
| status_o | output | 8 | {summary, periodic, alarm, update, 4'b0} |
| irq_drive_o | output | 1 | Pull-down enable for the open-drain interrupt line |
| upd_en_clr_o | output | 1 | One-cycle request to clear the stored update enable |

## Verification
The bench builds the block with its default of three sources and an eight-bit status byte. This is the only size that places the flags in the fixed positions 6..4 that the host decodes. At that size the bench reaches several cases: events that land before a read, during a read and exactly on the trailing-edge cycle; reads of one to four cycles held back to back; and enables and set mode toggled while flags are already pending.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned NUM_SRC = 3;
  localparam int unsigned STAT_W  = 8;

  typedef enum logic [1:0] {
    SRC_UPDATE   = 2'd0,
    SRC_ALARM    = 2'd1,
    SRC_PERIODIC = 2'd2
  } src_idx_e;
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic rd_i,
  input  logic rd_end_i,
  output logic flag_o,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      pend_o <= 1'b0;
    end else if (rd_end_i) begin
      // clear on trailing edge, merge parked and same-cycle event
      flag_o <= pend_o | evt_i;
      pend_o <= 1'b0;
    end else if (rd_i) begin
      pend_o <= pend_o | evt_i;
    end else begin
      flag_o <= flag_o | evt_i;
    end
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int unsigned NUM_SRC = 3,
  parameter int unsigned UPD_IDX = 0
) (
  input  logic [NUM_SRC-1:0] flags_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               set_mode_i,
  output logic               sum_o
);
  logic [NUM_SRC-1:0] en_eff;

  always_comb begin
    en_eff = en_i;
    if (set_mode_i) en_eff[UPD_IDX] = 1'b0;
    sum_o = |(flags_i & en_eff);
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
#(
  parameter int unsigned N_SRC  = NUM_SRC,
  parameter int unsigned DATA_W = STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic [N_SRC-1:0]  en_i,
  input  logic              set_mode_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_drive_o,
  output logic              upd_en_clr_o
);
  localparam int unsigned PAD_W = DATA_W - 1 - N_SRC;

  logic             rd_q, set_q, rd_end, sum;
  logic [N_SRC-1:0] flag_w, pend_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      set_q <= 1'b0;
    end else begin
      rd_q  <= rd_i;
      set_q <= set_mode_i;
    end
  end

  assign rd_end = rd_q & ~rd_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_cell
    irq_flag_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_i[g]),
      .rd_i    (rd_i),
      .rd_end_i(rd_end),
      .flag_o  (flag_w[g]),
      .pend_o  (pend_w[g])
    );
  end

  irq_summary #(.NUM_SRC(N_SRC), .UPD_IDX(int'(SRC_UPDATE))) u_sum (
    .flags_i   (flag_w),
    .en_i      (en_i),
    .set_mode_i(set_mode_i),
    .sum_o     (sum)
  );

  assign status_o     = {sum, flag_w, {PAD_W{1'b0}}};
  assign irq_drive_o  = sum;
  assign upd_en_clr_o = set_mode_i & ~set_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int unsigned N_SRC  = 3,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_SRC-1:0]  evt_i,
  input logic [N_SRC-1:0]  en_i,
  input logic              set_mode_i,
  input logic              rd_i,
  input logic              rd_q,
  input logic [N_SRC-1:0]  pend_w,
  input logic [DATA_W-1:0] status_o,
  input logic              irq_drive_o,
  input logic              upd_en_clr_o
);
  localparam int unsigned FL = DATA_W - 2;
  localparam int unsigned PAD_W = DATA_W - 1 - N_SRC;

  assert_pad_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[PAD_W-1:0] == '0);

  assert_summary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[DATA_W-1] == |(status_o[FL -: N_SRC] & (en_i & ~{{(N_SRC-1){1'b0}}, set_mode_i})));

  assert_flag_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !rd_q && evt_i != '0) |=> ((status_o[FL -: N_SRC] & $past(evt_i)) == $past(evt_i)));

  assert_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_drive_o == status_o[DATA_W-1]);

  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q && !rd_i && pend_w == '0 && evt_i == '0) |=> status_o[FL -: N_SRC] == '0);

  assert_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_q) |-> $stable(status_o[FL -: N_SRC]));

  assert_clr_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_mode_i |-> !upd_en_clr_o);
endmodule

bind irq_status_reg irq_status_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .en_i(en_i),
  .set_mode_i(set_mode_i), .rd_i(rd_i), .rd_q(rd_q), .pend_w(pend_w),
  .status_o(status_o), .irq_drive_o(irq_drive_o), .upd_en_clr_o(upd_en_clr_o)
);

// File: tb/sim_irq_status_reg.sv
module sim_irq_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] evt = '0, en = '0;
  logic       set_mode = 1'b0, rd = 1'b0;
  logic [7:0] status;
  logic       irq, clr;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  irq_status_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .en_i(en), .set_mode_i(set_mode),
    .rd_i(rd), .status_o(status), .irq_drive_o(irq), .upd_en_clr_o(clr)
  );

  // behavioural reference: per-source flag and parked event
  bit m_flag[3], m_park[3];
  bit m_rd_prev, m_set_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_flag[k]) begin m_flag[k] = 0; m_park[k] = 0; end
      m_rd_prev = 0; m_set_prev = 0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (m_rd_prev && !rd) begin
          m_flag[k] = m_park[k] | evt[k];
          m_park[k] = 0;
        end else if (rd) m_park[k] = m_park[k] | evt[k];
        else m_flag[k] = m_flag[k] | evt[k];
      end
      m_rd_prev = rd;
      m_set_prev = set_mode;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_model();
    bit s;
    s = (m_flag[2] & en[2]) | (m_flag[1] & en[1]) | (m_flag[0] & en[0] & !set_mode);
    chk("R3 flags", int'(status[6:4]), int'({m_flag[2], m_flag[1], m_flag[0]}));
    chk("R2 summary", int'(status[7]), int'(s));
    chk("R4 irq", int'(irq), int'(status[7]));
    chk("R1 pad", int'(status[3:0]), 0);
    chk("R8 clr req", int'(clr), int'(set_mode & !m_set_prev));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_model();
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (2) @(negedge clk);
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    tick();
    // R3: periodic event with enable off
    evt = 3'b100; tick(); evt = '0;
    chk("R3 periodic flag unenabled", int'(status), 'h40);
    chk("R4 irq quiet", int'(irq), 0);
    tick();
    // R7: late enable raises irq at once
    en = 3'b100; #1;
    chk("R7 late enable", int'(status), 'hC0);
    chk("R7 irq", int'(irq), 1);
    tick();
    // R6: read with alarm arriving mid-read
    rd = 1'b1; tick(); held = status;
    evt = 3'b010; tick(); evt = '0;
    chk("R6 stable during read", int'(status), int'(held));
    tick();
    rd = 1'b0; tick();
    chk("R5 R6 cleared, parked alarm applied", int'(status), 'h20);
    // R6: event on the trailing-edge cycle
    rd = 1'b1; tick(); tick();
    rd = 1'b0; evt = 3'b001; tick(); evt = '0;
    chk("R6 trailing-edge event kept", int'(status), 'h10);
    // R5: read with nothing pending
    rd = 1'b1; tick(); rd = 1'b0; tick();
    chk("R5 all clear", int'(status), 'h00);
    // R2 R8: update enable masked in set mode
    en = 3'b001; evt = 3'b001; tick(); evt = '0;
    chk("R2 update enabled", int'(status), 'h90);
    set_mode = 1'b1; #1;
    chk("R8 clear request", int'(clr), 1);
    chk("R2 masked in set mode", int'(status[7]), 0);
    tick(); tick();
    chk("R8 single pulse", int'(clr), 0);
    set_mode = 1'b0; tick();
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      evt = 3'($urandom_range(0, 7) & $urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0) en = 3'($urandom);
      if ($urandom_range(0, 15) == 0) set_mode = ~set_mode;
      if (!rd && $urandom_range(0, 5) == 0) rd = 1'b1;
      else if (rd && $urandom_range(0, 2) == 0) rd = 1'b0;
      tick();
    end
    evt = '0; rd = 1'b0; tick();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule